// File: doc/BRIEF.md
# Rotating Banked Register File

This block stores a small set of words in rings that never stop moving. It is built from four independent banks. Each bank is a ring of four word slots, and every clock edge moves each word one position. The word that leaves the front of the ring is fed back into its tail. Only the front position of each bank, called its access point, can be read or written. All banks step together on every clock, whether or not any access is made.

A bank is chosen directly by a bank-select field, so it takes one step to reach any bank. Inside a bank there is no entry address. A client waits until the wanted entry rotates to the access point. Each bank reports a slot counter that gives the logical entry index present at the access point in the current cycle. With that counter a client can time a write or a read, or stream out a whole bank at one word per clock.

Top module: `rotary_rf`

## Requirements
- R1: Asynchronous reset (rst_ni low) clears every stored word to zero, drives every slot counter to 0 and holds rd_valid_o low.
- R2: Every bank's slot counter advances by one on each clock edge and wraps from 3 back to 0. All banks show the same slot value in every cycle.
- R3: When wr_en_i is high, the word at the access point of bank wr_bank_i is replaced by wr_data_i on that edge. A later read of the same logical entry returns the new word.
- R4: A write changes only the selected bank. The same logical entry in every other bank keeps its value.
- R5: Without a write, stored words keep circulating unchanged for any number of cycles.
- R6: When rd_en_i is high in a cycle, the next cycle shows rd_valid_o high and rd_data_o equal to the word that was at the access point of bank rd_bank_i. When rd_en_i is low, rd_valid_o is low in the next cycle.
- R7: When a read and a write hit the same bank in the same cycle, the read returns the word held before the write. The written word is then stored.
- R8: Reads held on a bank for consecutive cycles, starting when the slot counter shows 0, return entries 0, 1, 2, 3 in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all rings rotate on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the current access point |
| wr_bank_i | input | 2 | Bank targeted by the write |
| wr_data_i | input | 16 | Word to store |
| rd_en_i | input | 1 | Read strobe for the current access point |
| rd_bank_i | input | 2 | Bank targeted by the read |
| rd_data_o | output | 16 | Registered read word |
| rd_valid_o | output | 1 | High one cycle after a read strobe |
| slot_o | output | 8 | Per-bank slot counter, bank b in bits [2b+1:2b] |

## Verification
Each result has a fixed due cycle. A write presented while the slot counter shows entry e is captured on the next rising edge. A read of entry e is strobed while the counter shows e, and its data and valid flag are due exactly one edge later. The bench drives inputs and samples outputs only on falling edges. It waits for the counter value before each access and checks read results at the first falling edge after the capture edge. That makes every expected value line up with one specific rising edge.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned RRF_DEF_BANKS = 4;
  localparam int unsigned RRF_DEF_DEPTH = 4;
  localparam int unsigned RRF_DEF_WIDTH = 16;
endpackage

// File: rtl/rrf_ring_bank.sv
module rrf_ring_bank #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned WIDTH  = 16,
  localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  output logic [WIDTH-1:0]  head_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [WIDTH-1:0]  ring_q [DEPTH];
  logic [SLOT_W-1:0] slot_q;

  // stages before the tail take the word from their successor
  for (genvar s = 0; s < DEPTH - 1; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ring_q[s] <= '0;
      else         ring_q[s] <= ring_q[s+1];
    end
  end

  // tail recirculates the head unless a write replaces it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ring_q[DEPTH-1] <= '0;
    else if (wr_en_i) ring_q[DEPTH-1] <= wr_data_i;
    else              ring_q[DEPTH-1] <= ring_q[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            slot_q <= '0;
    else if (slot_q == SLOT_W'(DEPTH - 1))  slot_q <= '0;
    else                                    slot_q <= slot_q + 1'b1;
  end

  assign head_o = ring_q[0];
  assign slot_o = slot_q;

  assert_slot_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SLOT_W'(DEPTH - 1));
  assert_slot_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == SLOT_W'(DEPTH - 1)) |=> (slot_q == '0));
  assert_recirc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (ring_q[DEPTH-1] == $past(head_o)));
  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ring_q[DEPTH-1] == $past(wr_data_i)));
endmodule

// File: rtl/rrf_bank_decoder.sv
module rrf_bank_decoder #(
  parameter int unsigned BANKS  = 4,
  localparam int unsigned SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [BANKS-1:0] hit_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_dec
    assign hit_o[b] = en_i && (sel_i == SEL_W'(b));
  end
endmodule

// File: rtl/rrf_read_port.sv
module rrf_read_port #(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned WIDTH  = 16,
  localparam int unsigned SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_en_i,
  input  logic [SEL_W-1:0]            rd_bank_i,
  input  logic [BANKS-1:0][WIDTH-1:0] heads_i,
  output logic [WIDTH-1:0]            rd_data_o,
  output logic                        rd_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= heads_i[rd_bank_i];
    end
  end

  assert_valid_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  assert_valid_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
endmodule

// File: rtl/rotary_rf.sv
module rotary_rf
  import rrf_pkg::*;
#(
  parameter int unsigned BANKS  = RRF_DEF_BANKS,
  parameter int unsigned DEPTH  = RRF_DEF_DEPTH,
  parameter int unsigned WIDTH  = RRF_DEF_WIDTH,
  localparam int unsigned SEL_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [SEL_W-1:0]        wr_bank_i,
  input  logic [WIDTH-1:0]        wr_data_i,
  input  logic                    rd_en_i,
  input  logic [SEL_W-1:0]        rd_bank_i,
  output logic [WIDTH-1:0]        rd_data_o,
  output logic                    rd_valid_o,
  output logic [BANKS*SLOT_W-1:0] slot_o
);
  logic [BANKS-1:0]             wr_hit;
  logic [BANKS-1:0][WIDTH-1:0]  heads;
  logic [BANKS-1:0][SLOT_W-1:0] slots;

  rrf_bank_decoder #(.BANKS(BANKS)) u_wr_dec (
    .en_i (wr_en_i),
    .sel_i(wr_bank_i),
    .hit_o(wr_hit)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    rrf_ring_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_hit[b]),
      .wr_data_i(wr_data_i),
      .head_o   (heads[b]),
      .slot_o   (slots[b])
    );
    assign slot_o[b*SLOT_W +: SLOT_W] = slots[b];

    assert_lockstep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slots[b] == slots[0]);
  end

  rrf_read_port #(.BANKS(BANKS), .WIDTH(WIDTH)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_bank_i (rd_bank_i),
    .heads_i   (heads),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o)
  );

  assert_single_bank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit));
  assert_old_on_collide_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && wr_en_i && rd_bank_i == wr_bank_i) |=>
      (rd_data_o == $past(heads[rd_bank_i])));
endmodule

// File: tb/rotary_rf_test.sv
`timescale 1ns/1ps
module rotary_rf_test;
  localparam int NB = 4;
  localparam int ND = 4;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_bank = '0;
  logic [W-1:0]  wr_data = '0;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_bank = '0;
  logic [W-1:0]  rd_data;
  logic          rd_valid;
  logic [7:0]    slot;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] exp_q [NB][ND];

  always #5 clk = ~clk;

  rotary_rf uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_bank_i(rd_bank),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .slot_o(slot)
  );

  task automatic print_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_slot(input int e);
    while (slot[1:0] != 2'(e)) @(negedge clk);
  endtask

  task automatic do_write(input int b, input int e, input logic [W-1:0] d);
    wait_slot(e);
    wr_en = 1'b1; wr_bank = 2'(b); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    exp_q[b][e] = d;
  endtask

  task automatic do_read(input int b, input int e, input string tag);
    wait_slot(e);
    rd_en = 1'b1; rd_bank = 2'(b);
    @(negedge clk);
    rd_en = 1'b0;
    check_val({tag, " valid"}, 32'(rd_valid), 32'd1);
    check_val({tag, " data"}, 32'(rd_data), 32'(exp_q[b][e]));
  endtask

  task automatic read_all(input string tag);
    for (int b = 0; b < NB; b++)
      for (int e = 0; e < ND; e++) do_read(b, e, tag);
  endtask

  task automatic t_reset();
    #23;
    check_val("R1 slot in reset", 32'(slot), 32'd0);
    check_val("R1 valid in reset", 32'(rd_valid), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int b = 0; b < NB; b++)
      for (int e = 0; e < ND; e++) exp_q[b][e] = '0;
    read_all("R1 cleared entry");
  endtask

  task automatic t_slot();
    logic [1:0] prev;
    prev = slot[1:0];
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      for (int b = 0; b < NB; b++)
        check_val("R2 slot step/lockstep", 32'(slot[b*2 +: 2]), 32'(2'(prev + 2'd1)));
      prev = slot[1:0];
    end
  endtask

  task automatic t_fill();
    for (int b = 0; b < NB; b++)
      for (int e = 0; e < ND; e++) do_write(b, e, W'(16'hA000 + b * 16 + e));
    read_all("R3 written entry");
  endtask

  task automatic t_isolate();
    do_write(2, 1, 16'h5A5A);
    do_read(0, 1, "R4 other bank 0");
    do_read(1, 1, "R4 other bank 1");
    do_read(3, 1, "R4 other bank 3");
    do_read(2, 1, "R3 target bank");
  endtask

  task automatic t_hold();
    repeat (37) @(negedge clk);
    read_all("R5 held entry");
  endtask

  task automatic t_collide();
    logic [W-1:0] old;
    old = exp_q[1][3];
    wait_slot(3);
    wr_en = 1'b1; wr_bank = 2'd1; wr_data = 16'hBEEF;
    rd_en = 1'b1; rd_bank = 2'd1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_val("R7 old word on collide", 32'(rd_data), 32'(old));
    exp_q[1][3] = 16'hBEEF;
    do_read(1, 3, "R7 new word stored");
  endtask

  task automatic t_stream();
    wait_slot(0);
    rd_en = 1'b1; rd_bank = 2'd3;
    for (int i = 0; i < ND; i++) begin
      @(negedge clk);
      if (i == ND - 1) rd_en = 1'b0;
      check_val("R8 stream valid", 32'(rd_valid), 32'd1);
      check_val("R8 stream data", 32'(rd_data), 32'(exp_q[3][i]));
    end
    @(negedge clk);
    check_val("R6 valid low when idle", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    print_summary();
    $finish;
  end

  initial begin
    t_reset();
    t_slot();
    t_fill();
    t_isolate();
    t_hold();
    t_collide();
    t_stream();
    print_summary();
    $finish;
  end
endmodule